// File: doc/BRIEF.md
# Operand Bypass and Load-Use Hazard Control

This block resolves data and control hazards for a five-stage in-order integer pipeline whose stages are fetch, decode with register read, execute, memory access and write back. It watches the source and destination register numbers held in the pipeline registers between those stages. From them it chooses, for each ALU operand, whether the value comes from the register file or is bypassed from a result that has not yet been written back.

A load result only becomes available at the end of the memory stage. An instruction in decode that reads the loaded register therefore cannot be fed by a bypass in time. The block detects this while the consumer is still in decode. It then holds the program counter and the fetch/decode register for one cycle, and inserts an all-zero control bubble into the decode/execute register.

Branches are predicted not taken and are resolved in decode. A taken branch discards the one instruction fetched behind it. The block is purely combinational; its outputs settle in the same cycle as its inputs.

Top module: `hazard_ctl`

## Requirements
- R1: When the EX/MEM stage writes a nonzero register equal to the execute-stage first source, the first operand select is 2'b10.
- R2: When the MEM/WB stage writes a nonzero register equal to the execute-stage first source, and R1 does not apply, the first operand select is 2'b01.
- R3: When both later stages write the first source register, the EX/MEM stage wins and the select is 2'b10.
- R4: A producer with its write enable low, or with destination register 0, causes no bypass; with no bypass the select is 2'b00 (register file).
- R5: The second operand select follows the rules of R1 to R4, using the execute-stage second source register instead of the first.
- R6: The stall output is high when the execute-stage instruction is a memory read with write enable high and a nonzero destination equal to either source register of the decode-stage instruction.
- R7: The bubble output is high in exactly the cycles in which stall is high.
- R8: The fetch/decode flush output is high when a branch is taken in decode and no stall is raised; during a stall the branch is held and no flush is issued.
- R9: A match between the execute-stage destination and a decode-stage source raises no stall when the memory-read flag is low, when write enable is low, or when the destination is register 0.
- R10: Neither operand select ever takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ifid_rs | input | REG_W | First source register of the instruction in decode |
| ifid_rt | input | REG_W | Second source register of the instruction in decode |
| idex_rs | input | REG_W | First source register of the instruction in execute |
| idex_rt | input | REG_W | Second source register of the instruction in execute |
| idex_rd | input | REG_W | Destination register of the instruction in execute |
| idex_wen | input | 1 | Register write enable of the instruction in execute |
| idex_memrd | input | 1 | Instruction in execute is a memory read (load) |
| exmem_rd | input | REG_W | Destination register in the EX/MEM stage |
| exmem_wen | input | 1 | Register write enable in the EX/MEM stage |
| memwb_rd | input | REG_W | Destination register in the MEM/WB stage |
| memwb_wen | input | 1 | Register write enable in the MEM/WB stage |
| br_taken | input | 1 | Branch resolved as taken in decode |
| fwd_a | output | 2 | First operand source: 00 register file, 10 EX/MEM, 01 MEM/WB |
| fwd_b | output | 2 | Second operand source, same encoding |
| stall | output | 1 | Hold the program counter and the fetch/decode register |
| bubble | output | 1 | Zero the control fields entering the decode/execute register |
| flush | output | 1 | Discard the instruction in the fetch/decode register |

## Verification
The bench builds the block with REG_W set to 3, so there are only eight registers. With so few registers, random register numbers collide often, and they land on register 0 often. Random stimulus therefore reaches the double-match priority case, the register-0 suppression and the load-use match within a few hundred cycles. A directed sequence comes first. It covers each bypass source, the priority between them, a load feeding either decode source, a load with write enable low, and a taken branch that arrives together with a stall.

// File: rtl/hazard_ctl.sv
module hazard_ctl #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] ifid_rs,
  input  logic [REG_W-1:0] ifid_rt,
  input  logic [REG_W-1:0] idex_rs,
  input  logic [REG_W-1:0] idex_rt,
  input  logic [REG_W-1:0] idex_rd,
  input  logic             idex_wen,
  input  logic             idex_memrd,
  input  logic [REG_W-1:0] exmem_rd,
  input  logic             exmem_wen,
  input  logic [REG_W-1:0] memwb_rd,
  input  logic             memwb_wen,
  input  logic             br_taken,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic             stall,
  output logic             bubble,
  output logic             flush
);

  localparam logic [1:0] SEL_RF = 2'b00;
  localparam logic [1:0] SEL_EX = 2'b10;
  localparam logic [1:0] SEL_WB = 2'b01;

  logic ex_live, wb_live, ld_live;
  logic ex_a, ex_b, wb_a, wb_b;
  logic ld_hit;

  assign ex_live = exmem_wen && (exmem_rd != '0);
  assign wb_live = memwb_wen && (memwb_rd != '0);
  assign ld_live = idex_memrd && idex_wen && (idex_rd != '0);

  assign ex_a = ex_live && (exmem_rd == idex_rs);
  assign ex_b = ex_live && (exmem_rd == idex_rt);
  assign wb_a = wb_live && (memwb_rd == idex_rs);
  assign wb_b = wb_live && (memwb_rd == idex_rt);

  assign fwd_a = ex_a ? SEL_EX : (wb_a ? SEL_WB : SEL_RF);
  assign fwd_b = ex_b ? SEL_EX : (wb_b ? SEL_WB : SEL_RF);

  assign ld_hit = ld_live && ((idex_rd == ifid_rs) || (idex_rd == ifid_rt));

  assign stall  = ld_hit;
  assign bubble = ld_hit;
  assign flush  = br_taken && !ld_hit;

endmodule

// File: rtl/hazard_ctl_chk.sv
module hazard_ctl_chk #(
  parameter int REG_W = 5
) (
  input logic [REG_W-1:0] ifid_rs,
  input logic [REG_W-1:0] ifid_rt,
  input logic [REG_W-1:0] idex_rs,
  input logic [REG_W-1:0] idex_rt,
  input logic [REG_W-1:0] idex_rd,
  input logic             idex_wen,
  input logic             idex_memrd,
  input logic [REG_W-1:0] exmem_rd,
  input logic             exmem_wen,
  input logic [REG_W-1:0] memwb_rd,
  input logic             memwb_wen,
  input logic             br_taken,
  input logic [1:0]       fwd_a,
  input logic [1:0]       fwd_b,
  input logic             stall,
  input logic             bubble,
  input logic             flush
);

  always_comb begin
    AST_SEL_LEGAL: assert (fwd_a != 2'b11 && fwd_b != 2'b11);                       // R10
    AST_EX_PRIORITY: assert (!(exmem_wen && exmem_rd != '0 && exmem_rd == idex_rs) || fwd_a == 2'b10); // R3
    AST_NO_ZERO_FWD: assert (fwd_a == 2'b00 || idex_rs != '0);                      // R4
    AST_WB_NEEDS_WEN: assert (fwd_b != 2'b01 || memwb_wen);                         // R5
    AST_STALL_CAUSE: assert (!stall || (idex_memrd && idex_wen));                   // R9
    AST_STALL_MATCH: assert (!stall || idex_rd == ifid_rs || idex_rd == ifid_rt);   // R6
    AST_BUBBLE_TRACKS: assert (bubble == stall);                                    // R7
    AST_FLUSH_HELD: assert (!(flush && stall) && (!flush || br_taken));             // R8
  end

endmodule

bind hazard_ctl hazard_ctl_chk #(.REG_W(REG_W)) u_chk (
  .ifid_rs(ifid_rs), .ifid_rt(ifid_rt),
  .idex_rs(idex_rs), .idex_rt(idex_rt), .idex_rd(idex_rd),
  .idex_wen(idex_wen), .idex_memrd(idex_memrd),
  .exmem_rd(exmem_rd), .exmem_wen(exmem_wen),
  .memwb_rd(memwb_rd), .memwb_wen(memwb_wen),
  .br_taken(br_taken),
  .fwd_a(fwd_a), .fwd_b(fwd_b), .stall(stall), .bubble(bubble), .flush(flush)
);

// File: tb/hazard_ctl_bench.sv
module hazard_ctl_bench;
  localparam int RW = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [RW-1:0] ifid_rs, ifid_rt, idex_rs, idex_rt, idex_rd, exmem_rd, memwb_rd;
  logic idex_wen, idex_memrd, exmem_wen, memwb_wen, br_taken;
  logic [1:0] fwd_a, fwd_b;
  logic stall, bubble, flush;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  hazard_ctl #(.REG_W(RW)) u_hazard_ctl (
    .ifid_rs(ifid_rs), .ifid_rt(ifid_rt),
    .idex_rs(idex_rs), .idex_rt(idex_rt), .idex_rd(idex_rd),
    .idex_wen(idex_wen), .idex_memrd(idex_memrd),
    .exmem_rd(exmem_rd), .exmem_wen(exmem_wen),
    .memwb_rd(memwb_rd), .memwb_wen(memwb_wen),
    .br_taken(br_taken),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .stall(stall), .bubble(bubble), .flush(flush)
  );

  function automatic int ref_sel(int src);
    if (exmem_wen && exmem_rd != 0 && int'(exmem_rd) == src) return 2;
    if (memwb_wen && memwb_rd != 0 && int'(memwb_rd) == src) return 1;
    return 0;
  endfunction

  function automatic string sel_tag(int e);
    if (e == 2) return "R1 R3";
    if (e == 1) return "R2";
    return "R4";
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    int ea, eb, es, ef;
    ea = ref_sel(int'(idex_rs));
    eb = ref_sel(int'(idex_rt));
    es = (idex_memrd && idex_wen && idex_rd != 0 &&
          (idex_rd == ifid_rs || idex_rd == ifid_rt)) ? 1 : 0;
    ef = (br_taken && es == 0) ? 1 : 0;
    check({"fwd_a ", sel_tag(ea)}, int'(fwd_a), ea);
    check("fwd_b R5", int'(fwd_b), eb);
    check("stall R6 R9", int'(stall), es);
    check("bubble R7", int'(bubble), es);
    check("flush R8", int'(flush), ef);
    check("legal R10", int'(fwd_a == 2'b11 || fwd_b == 2'b11), 0);
  endtask

  task automatic drive(int a_rs, int a_rt, int e_rs, int e_rt, int e_rd, int e_w, int e_m,
                       int m_rd, int m_w, int w_rd, int w_w, int br);
    @(posedge clk);
    ifid_rs = RW'(a_rs); ifid_rt = RW'(a_rt);
    idex_rs = RW'(e_rs); idex_rt = RW'(e_rt); idex_rd = RW'(e_rd);
    idex_wen = 1'(e_w); idex_memrd = 1'(e_m);
    exmem_rd = RW'(m_rd); exmem_wen = 1'(m_w);
    memwb_rd = RW'(w_rd); memwb_wen = 1'(w_w);
    br_taken = 1'(br);
    @(negedge clk);
    compare();
  endtask

  initial begin
    drive(0,0,0,0,0,0,0,0,0,0,0,0);                 // idle state
    drive(1,2,3,4,5,1,0,3,1,0,0,0);                 // R1 EX/MEM to A
    drive(1,2,3,4,5,1,0,0,0,3,1,0);                 // R2 MEM/WB to A
    drive(1,2,3,3,5,1,0,3,1,3,1,0);                 // R3 both match, EX/MEM wins
    drive(1,2,0,0,5,1,0,0,1,0,1,0);                 // R4 register 0
    drive(1,2,3,4,5,1,0,3,0,4,0,0);                 // R4 write enable low
    drive(1,2,3,4,5,1,0,4,1,4,1,0);                 // R5 operand B
    drive(6,2,3,4,6,1,1,0,0,0,0,0);                 // R6 load to rs
    drive(1,6,3,4,6,1,1,0,0,0,0,0);                 // R6 load to rt
    drive(6,2,3,4,6,1,0,0,0,0,0,0);                 // R9 not a load
    drive(6,2,3,4,6,0,1,0,0,0,0,0);                 // R9 wen low
    drive(0,2,3,4,0,1,1,0,0,0,0,0);                 // R9 register 0
    drive(1,2,3,4,5,1,0,0,0,0,0,1);                 // R8 taken, no stall
    drive(5,2,3,4,5,1,1,0,0,0,0,1);                 // R8 taken during stall
    for (int i = 0; i < 3000; i++)
      drive($urandom_range(0,7), $urandom_range(0,7), $urandom_range(0,7),
            $urandom_range(0,7), $urandom_range(0,7), $urandom_range(0,1),
            $urandom_range(0,1), $urandom_range(0,7), $urandom_range(0,1),
            $urandom_range(0,7), $urandom_range(0,1), $urandom_range(0,1));
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule